// File: doc/BRIEF.md
# Single-Core Chained-Permutation MAC Engine

This block computes a message authentication tag over a stream of 128-bit message words. It uses one iterative AES-128 round datapath, which does two jobs in turn. The first job is a full ten-round encryption under a stored key, with round keys derived on the fly. The second is a short permutation of four complete middle rounds with every round key forced to zero.

For each message, the chaining state starts as the keyed encryption of an all-zero block. The first word is XORed in straight away. Each later word is XORed in after the state has been through the short permutation. Once the padded message is absorbed, a last keyed encryption gives the 128-bit result. The tag is its leading bits, with the count set by `tag_len`.

Words arrive on a valid/ready port. The final word is marked with a last flag and a count of its valid bits, which sit at the top of the word. The engine pads the message itself. After a tag is produced, it primes the state for the next message under the same key without being asked. Loading a new key abandons any message in progress and primes the state again.

Top module: `smac_engine`

## Requirements
- R1: After reset, `in_ready`, `tag_done` and `tag_out` are all zero. No word is accepted until a key has been loaded.
- R2: A `key_we` pulse stores `key_in` and abandons any message in progress. The state becomes the encryption of zero under that key, and `in_ready` rises exactly 10 cycles after the loading edge.
- R3: The first word of a message is XORed into the primed state with no permutation in between.
- R4: Accepting a word that is not the last one starts four unkeyed rounds (SubBytes, ShiftRows, MixColumns, zero key). `in_ready` is low for exactly 4 cycles. The next word is XORed into the permuted state.
- R5: The last word is followed by a full keyed encryption under the stored key. For a partial last word, `tag_done` rises 10 cycles after that word is accepted.
- R6: Bit 127 of a word is the first message bit. In the last word, the top `in_nbits` bits are message bits. A 1 is placed at bit 127-`in_nbits` and every lower bit is cleared, so data bits below the valid ones have no effect on the tag.
- R7: If `in_nbits` is 128 or more, the last word is absorbed whole. After the four-round permutation, an extra block with only bit 127 set is XORed in, and then the final encryption runs. `tag_done` rises 14 cycles after acceptance.
- R8: `tag_out` holds the leading `tag_len` bits of the final state, and all lower bits are zero. A value of 128 or more gives the whole state. `tag_len` is sampled in the cycle the tag is produced.
- R9: `tag_done` is a one-cycle pulse. `tag_out` changes only in the cycle `tag_done` is high.
- R10: After a tag, the engine re-primes with the stored key on its own, and `in_ready` rises 10 cycles after the `tag_done` edge.
- R11: `in_ready` is low whenever a permutation is running. A word presented while `in_ready` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_we | input | 1 | Load `key_in` and restart priming |
| key_in | input | 128 | Cipher key |
| in_valid | input | 1 | Word present |
| in_ready | output | 1 | Engine can absorb a word |
| in_data | input | 128 | Message word, bit 127 first |
| in_last | input | 1 | Word is the last of the message |
| in_nbits | input | 8 | Valid bits in the last word |
| tag_len | input | 8 | Tag length in bits |
| tag_out | output | 128 | Truncated tag, left-aligned |
| tag_done | output | 1 | One-cycle strobe: tag valid |

## Verification
The bench builds the engine with its default parameters: ten full rounds, four short rounds, and 8-bit bit-count and tag-length fields. With these values the AES-128 result can be checked against a published test vector. The 8-bit fields also let the bench drive bit counts and tag lengths above 128, so the clamping paths are exercised alongside the exact 0, 127 and 128 boundaries. A key reload in the middle of a message and junk words presented while busy are compared cycle by cycle against a behavioural model.

// File: rtl/smac_pkg.sv
package smac_pkg;
  localparam int BLK_W = 128;
  localparam int BYTES = BLK_W / 8;

  typedef logic [BLK_W-1:0] blk_t;
  typedef enum logic [1:0] {PH_NOKEY, PH_FULL, PH_SHORT, PH_ABSORB} phase_t;

  function automatic logic [7:0] gf_dbl(input logic [7:0] x);
    return {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r, aa;
    r  = 8'h00;
    aa = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ aa;
      aa = gf_dbl(aa);
    end
    return r;
  endfunction

  // S-box: inverse as x^254 (product of the squarings x^2..x^128), then affine map
  function automatic logic [7:0] sub_byte(input logic [7:0] x);
    logic [7:0] p, acc;
    p   = x;
    acc = 8'h01;
    for (int i = 1; i < 8; i++) begin
      p   = gf_mul(p, p);
      acc = gf_mul(acc, p);
    end
    return acc ^ {acc[6:0], acc[7]} ^ {acc[5:0], acc[7:6]} ^
           {acc[4:0], acc[7:5]} ^ {acc[3:0], acc[7:4]} ^ 8'h63;
  endfunction

  function automatic blk_t lead_mask(input int lm);
    blk_t m;
    for (int i = 0; i < BLK_W; i++) m[BLK_W-1-i] = (i < lm);
    return m;
  endfunction
endpackage

// File: rtl/smac_round.sv
module smac_round
  import smac_pkg::*;
(
  input  blk_t st_i,
  input  blk_t rk_i,
  input  logic mix_i,
  output blk_t st_o
);
  logic [7:0] sb [BYTES];
  logic [7:0] sr [BYTES];
  logic [7:0] mc [BYTES];

  for (genvar i = 0; i < BYTES; i++) begin : g_sub
    assign sb[i] = sub_byte(st_i[BLK_W-1-8*i -: 8]);
  end

  for (genvar c = 0; c < 4; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      assign sr[r+4*c] = sb[r+4*((c+r)%4)];
    end
    assign mc[4*c+0] = gf_dbl(sr[4*c]) ^ gf_dbl(sr[4*c+1]) ^ sr[4*c+1] ^ sr[4*c+2] ^ sr[4*c+3];
    assign mc[4*c+1] = sr[4*c] ^ gf_dbl(sr[4*c+1]) ^ gf_dbl(sr[4*c+2]) ^ sr[4*c+2] ^ sr[4*c+3];
    assign mc[4*c+2] = sr[4*c] ^ sr[4*c+1] ^ gf_dbl(sr[4*c+2]) ^ gf_dbl(sr[4*c+3]) ^ sr[4*c+3];
    assign mc[4*c+3] = gf_dbl(sr[4*c]) ^ sr[4*c] ^ sr[4*c+1] ^ sr[4*c+2] ^ gf_dbl(sr[4*c+3]);
  end

  for (genvar i = 0; i < BYTES; i++) begin : g_out
    assign st_o[BLK_W-1-8*i -: 8] = (mix_i ? mc[i] : sr[i]) ^ rk_i[BLK_W-1-8*i -: 8];
  end
endmodule

// File: rtl/smac_keystep.sv
module smac_keystep
  import smac_pkg::*;
(
  input  blk_t       rk_i,
  input  logic [7:0] rcon_i,
  output blk_t       rk_o
);
  logic [31:0] w0, w1, w2, w3, t, n0, n1, n2, n3;

  assign w0 = rk_i[127:96];
  assign w1 = rk_i[95:64];
  assign w2 = rk_i[63:32];
  assign w3 = rk_i[31:0];
  assign t  = {sub_byte(w3[23:16]) ^ rcon_i, sub_byte(w3[15:8]),
               sub_byte(w3[7:0]), sub_byte(w3[31:24])};
  assign n0 = w0 ^ t;
  assign n1 = w1 ^ n0;
  assign n2 = w2 ^ n1;
  assign n3 = w3 ^ n2;
  assign rk_o = {n0, n1, n2, n3};
endmodule

// File: rtl/smac_pad.sv
module smac_pad
  import smac_pkg::*;
#(
  parameter int NB_W = 8
) (
  input  blk_t            data_i,
  input  logic [NB_W-1:0] nbits_i,
  output blk_t            word_o,
  output logic            extra_o
);
  blk_t keep, mark;
  int   mark_pos;

  always_comb begin
    extra_o  = (int'(nbits_i) >= BLK_W);
    mark_pos = extra_o ? 0 : BLK_W - 1 - int'(nbits_i);
    keep     = ~({BLK_W{1'b1}} >> nbits_i);
    mark     = blk_t'(1) << mark_pos;
    word_o   = extra_o ? data_i : ((data_i & keep) | mark);
  end

  always_comb begin
    if (!extra_o) begin
      AST_PAD_MARK: assert (word_o[mark_pos] == 1'b1);                                  // R6
      AST_PAD_TAIL: assert ((word_o & ({BLK_W{1'b1}} >> (int'(nbits_i) + 1))) == '0);  // R6
    end
  end
endmodule

// File: rtl/smac_engine.sv
module smac_engine
  import smac_pkg::*;
#(
  parameter int FULL_ROUNDS  = 10,
  parameter int SHORT_ROUNDS = 4,
  parameter int NB_W         = 8,
  parameter int LEN_W        = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_we,
  input  logic [BLK_W-1:0]  key_in,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BLK_W-1:0]  in_data,
  input  logic              in_last,
  input  logic [NB_W-1:0]   in_nbits,
  input  logic [LEN_W-1:0]  tag_len,
  output logic [BLK_W-1:0]  tag_out,
  output logic              tag_done
);
  localparam int   RND_W   = $clog2(FULL_ROUNDS + 1);
  localparam blk_t PAD_BLK = {1'b1, {(BLK_W-1){1'b0}}};

  phase_t           ph;
  blk_t             st, rk, key_q, tag_q;
  logic [7:0]       rcon;
  logic [RND_W-1:0] rnd;
  logic             fin, pad_pend, done_q;

  blk_t rk_nx, rnd_key, rnd_out, pad_w, absorb_w, mixed;
  logic pad_extra, use_mix;

  smac_keystep u_ks (.rk_i(rk), .rcon_i(rcon), .rk_o(rk_nx));

  assign rnd_key = (ph == PH_SHORT) ? '0 : rk_nx;
  assign use_mix = (ph == PH_SHORT) || (rnd != RND_W'(FULL_ROUNDS));

  smac_round u_rnd (.st_i(st), .rk_i(rnd_key), .mix_i(use_mix), .st_o(rnd_out));

  smac_pad #(.NB_W(NB_W)) u_pad (
    .data_i(in_data), .nbits_i(in_nbits), .word_o(pad_w), .extra_o(pad_extra)
  );

  assign absorb_w = in_last ? pad_w : in_data;
  assign mixed    = st ^ absorb_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_NOKEY;
      st       <= '0;
      rk       <= '0;
      key_q    <= '0;
      tag_q    <= '0;
      rcon     <= 8'h01;
      rnd      <= '0;
      fin      <= 1'b0;
      pad_pend <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (key_we) begin
        key_q    <= key_in;
        st       <= key_in;
        rk       <= key_in;
        rcon     <= 8'h01;
        rnd      <= RND_W'(1);
        fin      <= 1'b0;
        pad_pend <= 1'b0;
        ph       <= PH_FULL;
      end else begin
        unique case (ph)
          PH_FULL: begin
            st   <= rnd_out;
            rk   <= rk_nx;
            rcon <= gf_dbl(rcon);
            rnd  <= rnd + RND_W'(1);
            if (rnd == RND_W'(FULL_ROUNDS)) begin
              if (fin) begin
                tag_q  <= rnd_out & lead_mask(int'(tag_len));
                done_q <= 1'b1;
                st     <= key_q;
                rk     <= key_q;
                rcon   <= 8'h01;
                rnd    <= RND_W'(1);
                fin    <= 1'b0;
              end else begin
                ph <= PH_ABSORB;
              end
            end
          end
          PH_SHORT: begin
            st  <= rnd_out;
            rnd <= rnd + RND_W'(1);
            if (rnd == RND_W'(SHORT_ROUNDS)) begin
              if (pad_pend) begin
                st       <= rnd_out ^ PAD_BLK ^ key_q;
                rk       <= key_q;
                rcon     <= 8'h01;
                rnd      <= RND_W'(1);
                fin      <= 1'b1;
                pad_pend <= 1'b0;
                ph       <= PH_FULL;
              end else begin
                ph <= PH_ABSORB;
              end
            end
          end
          PH_ABSORB: begin
            if (in_valid) begin
              if (in_last && !pad_extra) begin
                st   <= mixed ^ key_q;
                rk   <= key_q;
                rcon <= 8'h01;
                rnd  <= RND_W'(1);
                fin  <= 1'b1;
                ph   <= PH_FULL;
              end else begin
                st       <= mixed;
                rnd      <= RND_W'(1);
                pad_pend <= in_last;
                ph       <= PH_SHORT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign in_ready = (ph == PH_ABSORB);
  assign tag_out  = tag_q;
  assign tag_done = done_q;

  AST_KEY_BUSY: assert property (@(posedge clk) disable iff (rst) key_we |=> !in_ready);                                   // R2
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst) (in_valid && in_ready && !key_we) |=> !in_ready);     // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) tag_done |=> !tag_done);                               // R9
  AST_TAG_HOLD: assert property (@(posedge clk) disable iff (rst) !$stable(tag_out) |-> tag_done);                          // R9
  AST_TAG_TAIL: assert property (@(posedge clk) disable iff (rst) tag_done |-> ((tag_out & ~lead_mask(int'($past(tag_len)))) == '0)); // R8
  AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (rst) tag_done |-> !in_ready);                           // R10
endmodule

// File: tb/smac_engine_tb_top.sv
`timescale 1ns/1ps
module smac_engine_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         key_we = 1'b0;
  logic [127:0] key_in = '0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_data = '0;
  logic         in_last = 1'b0;
  logic [7:0]   in_nbits = '0;
  logic [7:0]   tag_len = 8'd128;
  logic [127:0] tag_out;
  logic         tag_done;

  always #2.5 clk = ~clk;

  smac_engine dut_i (
    .clk(clk), .rst(rst), .key_we(key_we), .key_in(key_in),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .in_nbits(in_nbits), .tag_len(tag_len),
    .tag_out(tag_out), .tag_done(tag_done)
  );

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";

  // ---------------- behavioural AES ----------------
  logic [7:0] sb [256];
  initial begin
    logic [7:0] p, q, x;
    p = 8'h01; q = 8'h01;
    do begin
      p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b0};
      q = q ^ {q[3:0], 4'b0};
      if (q[7]) q = q ^ 8'h09;
      x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]};
      sb[p] = x ^ 8'h63;
    end while (p != 8'h01);
    sb[0] = 8'h63;
  end

  function automatic logic [7:0] xt(input logic [7:0] v);
    return {v[6:0], 1'b0} ^ (v[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [127:0] b_round(input logic [127:0] s, input logic [127:0] k, input bit mix);
    logic [7:0] a [16];
    logic [7:0] b [16];
    logic [7:0] o [16];
    logic [127:0] r;
    for (int i = 0; i < 16; i++) a[i] = sb[s[127-8*i -: 8]];
    for (int i = 0; i < 16; i++) b[i] = a[(i % 4) + 4 * (((i / 4) + (i % 4)) % 4)];
    for (int c = 0; c < 4; c++) begin
      for (int j = 0; j < 4; j++) begin
        if (mix)
          o[4*c+j] = xt(b[4*c+j]) ^ xt(b[4*c+(j+1)%4]) ^ b[4*c+(j+1)%4] ^ b[4*c+(j+2)%4] ^ b[4*c+(j+3)%4];
        else
          o[4*c+j] = b[4*c+j];
      end
    end
    for (int i = 0; i < 16; i++) r[127-8*i -: 8] = o[i];
    return r ^ k;
  endfunction

  function automatic logic [127:0] aes(input logic [127:0] key, input logic [127:0] pt);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0]  rc;
    logic [127:0] s;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    rc = 8'h01;
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {sb[t[23:16]] ^ rc, sb[t[15:8]], sb[t[7:0]], sb[t[31:24]]};
        rc = xt(rc);
      end
      w[i] = w[i-4] ^ t;
    end
    s = pt ^ key;
    for (int r = 1; r <= 10; r++) s = b_round(s, {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]}, r != 10);
    return s;
  endfunction

  function automatic logic [127:0] perm4(input logic [127:0] s);
    logic [127:0] v = s;
    for (int r = 0; r < 4; r++) v = b_round(v, '0, 1'b1);
    return v;
  endfunction

  function automatic logic [127:0] pad_last(input logic [127:0] d, input int nb);
    logic [127:0] v = '0;
    if (nb >= 128) return d;
    for (int i = 0; i < nb; i++) v[127-i] = d[127-i];
    v[127-nb] = 1'b1;
    return v;
  endfunction

  function automatic logic [127:0] trunc(input logic [127:0] s, input int lm);
    logic [127:0] v = '0;
    for (int i = 0; i < 128 && i < lm; i++) v[127-i] = s[127-i];
    return v;
  endfunction

  localparam logic [127:0] PADB = {1'b1, 127'b0};

  // ---------------- cycle model ----------------
  int m_ph = 0;           // 0 no key, 1 busy, 2 absorbing
  int m_cnt = 0;
  bit m_after_tag = 0;
  bit m_done = 0;
  logic [127:0] m_key = '0, m_st = '0, m_tag = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_cnt = 0; m_done = 0; m_tag = '0;
    end else begin
      m_done = 0;
      if (key_we) begin
        m_key = key_in; m_st = aes(m_key, '0); m_cnt = 10; m_after_tag = 0; m_ph = 1;
      end else if (m_ph == 1) begin
        m_cnt--;
        if (m_cnt == 0) begin
          if (m_after_tag) begin
            m_tag = trunc(m_st, int'(tag_len)); m_done = 1;
            m_st = aes(m_key, '0); m_cnt = 10; m_after_tag = 0;
          end else m_ph = 2;
        end
      end else if (m_ph == 2 && in_valid) begin
        if (!in_last) begin
          m_st = perm4(m_st ^ in_data); m_cnt = 4; m_after_tag = 0;
        end else if (in_nbits >= 8'd128) begin
          m_st = aes(m_key, perm4(m_st ^ in_data) ^ PADB); m_cnt = 14; m_after_tag = 1;
        end else begin
          m_st = aes(m_key, m_st ^ pad_last(in_data, int'(in_nbits))); m_cnt = 10; m_after_tag = 1;
        end
        m_ph = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      n_cmp += 3;
      if (in_ready !== (m_ph == 2)) begin
        n_bad++; $display("FAIL R11 ready: actual %0b expected %0b", in_ready, m_ph == 2);
      end
      if (tag_done !== m_done) begin
        n_bad++; $display("FAIL R9 done (%s): actual %0b expected %0b", cur_req, tag_done, m_done);
      end
      if (tag_out !== m_tag) begin
        n_bad++; $display("FAIL %s tag: actual %h expected %h", cur_req, tag_out, m_tag);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++; $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load_key(input logic [127:0] k);
    @(negedge clk); key_we = 1'b1; key_in = k;
    @(negedge clk); key_we = 1'b0;
  endtask

  task automatic send(input logic [127:0] d, input bit last, input int nb);
    @(negedge clk); in_valid = 1'b1; in_data = d; in_last = last; in_nbits = 8'(nb);
    while (!in_ready) @(negedge clk);
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic wait_done(output logic [127:0] t);
    while (!m_done) @(negedge clk);
    t = tag_out;
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_bad++; $display("FAIL watchdog: actual %0d expected 0", wd);
      finish_run();
    end
  end

  // ---------------- scenarios ----------------
  localparam logic [127:0] K1 = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] K2 = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] DA = 128'h6bc1bee22e409f96e93d7e117393172a;
  localparam logic [127:0] DB = 128'hae2d8a571e03ac9c9eb76fac45af8e51;
  localparam logic [127:0] DC = 128'h30c81c46a35ce411e5fbc1191a0a52ef;

  initial begin
    logic [127:0] t1, t2, e0, ex;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk(in_ready == 1'b0 && tag_done == 1'b0 && tag_out == '0, "R1 reset outputs", {tag_done, in_ready, tag_out[125:0]}, '0);
    rst = 1'b0;
    @(negedge clk); in_valid = 1'b1; in_data = DA; in_last = 1'b1; in_nbits = 8'd16;
    repeat (4) @(negedge clk);
    chk(in_ready == 1'b0 && tag_done == 1'b0, "R1 no accept without key", {127'b0, in_ready}, '0);
    in_valid = 1'b0;

    // bench model sanity: known AES-128 vector
    chk(aes(K1, 128'h00112233445566778899aabbccddeeff) == 128'h69c4e0d86a7b0430d8cdb78070b4c55a,
        "R5 model cipher vector", aes(K1, 128'h00112233445566778899aabbccddeeff), 128'h69c4e0d86a7b0430d8cdb78070b4c55a);

    // R2: priming takes 10 cycles
    cur_req = "R2";
    load_key(K1);
    repeat (9) @(negedge clk);
    chk(in_ready == 1'b0, "R2 still priming", {127'b0, in_ready}, '0);
    @(negedge clk);
    chk(in_ready == 1'b1, "R2 ready after 10", {127'b0, in_ready}, 128'd1);

    // R3/R5/R6: one partial word
    cur_req = "R3";
    e0 = aes(K1, '0);
    send(DA, 1'b1, 40);
    wait_done(t1);
    ex = aes(K1, e0 ^ pad_last(DA, 40));
    chk(t1 == ex, "R3 R5 single-word tag", t1, ex);

    // R9: pulse and hold; R10: re-prime 10 cycles after done
    @(negedge clk);
    chk(tag_done == 1'b0 && tag_out == t1, "R9 pulse ends, tag holds", tag_out, t1);
    cur_req = "R10";
    repeat (8) @(negedge clk);
    chk(in_ready == 1'b0, "R10 re-priming", {127'b0, in_ready}, '0);
    @(negedge clk);
    chk(in_ready == 1'b1, "R10 ready again", {127'b0, in_ready}, 128'd1);

    // R6: junk below valid bits ignored
    cur_req = "R6";
    send(DA ^ 128'h0000000000ffffffffffffffffffff55, 1'b1, 40);
    wait_done(t2);
    chk(t2 == t1, "R6 low junk ignored", t2, t1);

    // R4/R7: three words, last full -> extra pad block
    cur_req = "R7";
    send(DA, 1'b0, 0);
    send(DB, 1'b0, 0);
    send(DC, 1'b1, 128);
    wait_done(t1);
    ex = aes(K1, perm4(perm4(perm4(e0 ^ DA) ^ DB) ^ DC) ^ PADB);
    chk(t1 == ex, "R4 R7 three-word full tag", t1, ex);

    // R11: junk while busy, last word with 0 valid bits
    cur_req = "R11";
    send(DB, 1'b0, 0);
    @(negedge clk); in_valid = 1'b1; in_data = '1; in_last = 1'b1; in_nbits = 8'd5;
    @(negedge clk); @(negedge clk); in_valid = 1'b0;
    send(DC, 1'b1, 0);
    wait_done(t1);
    ex = aes(K1, perm4(e0 ^ DB) ^ PADB);
    chk(t1 == ex, "R11 busy junk ignored, nbits 0", t1, ex);

    // R8: truncation lengths
    cur_req = "R8";
    tag_len = 8'd32;
    send(DC, 1'b1, 127);
    wait_done(t1);
    ex = trunc(aes(K1, e0 ^ pad_last(DC, 127)), 32);
    chk(t1 == ex && t1[95:0] == '0, "R8 32-bit tag", t1, ex);
    tag_len = 8'd0;
    send(DB, 1'b1, 8);
    wait_done(t1);
    chk(t1 == '0, "R8 zero-length tag", t1, '0);
    tag_len = 8'd200;
    send(DB, 1'b1, 200);
    wait_done(t1);
    ex = aes(K1, perm4(e0 ^ DB) ^ PADB);
    chk(t1 == ex, "R8 R7 clamp above 128", t1, ex);
    tag_len = 8'd128;

    // R2: key reload mid-message abandons it
    cur_req = "R2";
    send(DA, 1'b0, 0);
    load_key(K2);
    send(DB, 1'b1, 64);
    wait_done(t1);
    ex = aes(K2, aes(K2, '0) ^ pad_last(DB, 64));
    chk(t1 == ex, "R2 reload restarts message", t1, ex);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule